// File: doc/BRIEF.md
# Inter-Processor Signal Interrupt Controller

This block carries doorbell signals between processors through a small register window. Each signal is addressed by a packed 32-bit identifier. The upper half of the identifier holds a client number and the lower half holds a signal number within that client.

To send a doorbell, software writes an identifier to a send register. The block then pulses the matching outbound line for one clock cycle. On the receive side, single-cycle pulses from the clients are latched as pending bits. Each signal has its own enable bit. Any signal that is both pending and enabled drives one active-high, level-sensitive summary interrupt.

All control is indirect: enable, disable, clear and send each take an identifier written to a strobe register. The service routine works as a loop:
1. Read the receive register to get the lowest-numbered pending, enabled identifier.
2. Clear that identifier.
3. Handle the signal.
4. Read again, and stop when the all-ones sentinel comes back.

Top module: `sig_irq_ctrl`

## Requirements
- R1: An identifier carries the client number in bits 31:16 and the signal number in bits 15:0. Signal (c, s) maps to flat line index c*NUM_SIGNALS+s on both the inbound and the outbound vectors.
- R2: A write of an in-range identifier to offset 0x0C makes `sig_out` one-hot on that signal's line for exactly the one cycle after the write edge, and zero otherwise.
- R3: An inbound pulse sets the signal's pending bit even while the signal is disabled. A disabled pending signal is not reported and does not raise the interrupt.
- R4: A write to offset 0x14 enables the addressed signal, and a write to offset 0x18 disables it. No other signal's enable changes.
- R5: A read strobe at offset 0x10 returns, on `bus_rdata` in the cycle after the strobe, the identifier of the pending and enabled signal with the lowest client number, ties going to the lowest signal number.
- R6: The receive read returns 0xFFFFFFFF when no enabled signal is pending.
- R7: A write of an identifier to offset 0x1C clears that signal's pending bit.
- R8: A write of a client number to offset 0x38 clears every pending bit of that client.
- R9: `irq_out` is high exactly while at least one signal is both pending and enabled.
- R10: A write whose client or signal number is out of range is ignored. This covers send, enable, disable, clear and client clear.
- R11: An inbound pulse and a clear of the same signal in the same cycle leave the signal pending.
- R12: After reset, all signals are disabled, nothing is pending, and `irq_out`, `sig_out` and `bus_rdata` are zero.
- R13: Reads of unmapped offsets return zero, and writes to them change nothing. A cycle without a read strobe leaves `bus_rdata` at zero. Reading the receive register has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| sig_in | input | NUM_CLIENTS*NUM_SIGNALS | Inbound pulses from clients |
| sig_out | output | NUM_CLIENTS*NUM_SIGNALS | Outbound one-cycle doorbell pulses |
| irq_out | output | 1 | Level summary interrupt |

## Verification
The bench builds the block with 4 clients of 8 signals each. With these values, client number 4 and signal number 8 are the first out-of-range values, so the bench can check that such writes are ignored right at the boundary. Eight lines per client let several pending signals from two clients compete at once, which exercises the client-first, then signal order of the receive read. The same values also let a client-wide clear be checked against a neighbouring client that must stay untouched.

// File: rtl/sic_pkg.sv
// Shared constants for the signal interrupt controller: register offsets
// and the no-pending sentinel. Assumes byte offsets fit in 8 bits.
package sic_pkg;
    localparam int          ADDR_W      = 8;
    localparam int          DATA_W      = 32;
    localparam int          FIELD_W     = 16;
    localparam logic [7:0]  OFF_SEND    = 8'h0C;
    localparam logic [7:0]  OFF_RECV    = 8'h10;
    localparam logic [7:0]  OFF_ENABLE  = 8'h14;
    localparam logic [7:0]  OFF_DISABLE = 8'h18;
    localparam logic [7:0]  OFF_CLEAR   = 8'h1C;
    localparam logic [7:0]  OFF_CLICLR  = 8'h38;
    localparam logic [31:0] NONE_ID     = 32'hFFFF_FFFF;
endpackage

// File: rtl/sic_id_decode.sv
// Decodes a written bus word two ways: as a packed client/signal
// identifier into a one-hot line vector, and as a plain client number
// into a mask of all that client's lines. Out-of-range values yield zero.
// Assumes NUM_CLIENTS and NUM_SIGNALS are each below 65536.
module sic_id_decode #(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    localparam int LINES      = NUM_CLIENTS * NUM_SIGNALS
) (
    input  logic [31:0]      word,
    output logic             id_ok,
    output logic [LINES-1:0] id_hot,
    output logic [LINES-1:0] cli_mask
);
    logic [15:0] cli_f;
    logic [15:0] sig_f;

    assign cli_f = word[31:16];
    assign sig_f = word[15:0];

    // Range check of both identifier fields
    assign id_ok = ({16'd0, cli_f} < 32'(NUM_CLIENTS)) &&
                   ({16'd0, sig_f} < 32'(NUM_SIGNALS));

    // Build the one-hot line and the whole-client mask
    always_comb begin
        id_hot   = '0;
        cli_mask = '0;
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            for (int s = 0; s < NUM_SIGNALS; s++) begin
                id_hot[c*NUM_SIGNALS+s]   = id_ok && (cli_f == 16'(c)) && (sig_f == 16'(s));
                cli_mask[c*NUM_SIGNALS+s] = (word == 32'(c));
            end
        end
    end
endmodule

// File: rtl/sic_state_bank.sv
// Holds the pending and enable bit of every signal line. An inbound set
// wins over a clear in the same cycle. Enable and disable strobes never
// arrive together, because they come from different offsets.
module sic_state_bank #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_vec,
    input  logic [LINES-1:0] clr_vec,
    input  logic [LINES-1:0] ena_vec,
    input  logic [LINES-1:0] dis_vec,
    output logic [LINES-1:0] pend,
    output logic [LINES-1:0] en
);
    // Pending bits: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= set_vec | (pend & ~clr_vec);
    end

    // Enable bits: per-line set and reset strobes
    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else        en <= ena_vec | (en & ~dis_vec);
    end

    for (genvar i = 0; i < LINES; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> pend[i]); // R11
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !pend[i]); // R7
        AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (dis_vec[i] && !ena_vec[i]) |=> !en[i]); // R4
    end
endmodule

// File: rtl/sic_prio_pick.sv
// Finds the lowest active line, which means lowest client first and then
// lowest signal, and reports its client and signal numbers. Purely
// combinational.
module sic_prio_pick #(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    localparam int LINES      = NUM_CLIENTS * NUM_SIGNALS
) (
    input  logic [LINES-1:0] active,
    output logic             found,
    output logic [15:0]      cli_num,
    output logic [15:0]      sig_num
);
    // Scan from the top so the lowest hit is written last
    always_comb begin
        found   = 1'b0;
        cli_num = '0;
        sig_num = '0;
        for (int c = NUM_CLIENTS - 1; c >= 0; c--) begin
            for (int s = NUM_SIGNALS - 1; s >= 0; s--) begin
                if (active[c*NUM_SIGNALS+s]) begin
                    found   = 1'b1;
                    cli_num = 16'(c);
                    sig_num = 16'(s);
                end
            end
        end
    end
endmodule

// File: rtl/sig_irq_ctrl.sv
// Top level of the signal interrupt controller. It decodes strobe writes
// into per-line actions, registers outbound pulses and read data, and
// drives the level summary interrupt. Assumes a single-cycle synchronous
// register bus with no wait states; read data appears the cycle after
// the read strobe.
module sig_irq_ctrl
    import sic_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    localparam int LINES      = NUM_CLIENTS * NUM_SIGNALS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  sig_in,
    output logic [LINES-1:0]  sig_out,
    output logic              irq_out
);
    logic             id_ok;
    logic [LINES-1:0] id_hot, cli_mask;
    logic [LINES-1:0] clr_vec, ena_vec, dis_vec;
    logic [LINES-1:0] pend, en;
    logic             found;
    logic [15:0]      cli_num, sig_num;
    logic [31:0]      recv_id;

    sic_id_decode #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_dec (
        .word(bus_wdata), .id_ok(id_ok), .id_hot(id_hot), .cli_mask(cli_mask)
    );

    // Steer the decoded line masks by write offset
    always_comb begin
        ena_vec = (bus_wr && bus_addr == OFF_ENABLE)  ? id_hot : '0;
        dis_vec = (bus_wr && bus_addr == OFF_DISABLE) ? id_hot : '0;
        clr_vec = '0;
        if (bus_wr && bus_addr == OFF_CLEAR)  clr_vec = id_hot;
        if (bus_wr && bus_addr == OFF_CLICLR) clr_vec = cli_mask;
    end

    sic_state_bank #(.LINES(LINES)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(sig_in), .clr_vec(clr_vec),
        .ena_vec(ena_vec), .dis_vec(dis_vec), .pend(pend), .en(en)
    );

    sic_prio_pick #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_pick (
        .active(pend & en), .found(found), .cli_num(cli_num), .sig_num(sig_num)
    );

    assign recv_id = found ? {cli_num, sig_num} : NONE_ID;
    assign irq_out = |(pend & en);

    // Outbound doorbell pulse, one cycle per send write
    always_ff @(posedge clk) begin
        if (!rst_n)                              sig_out <= '0;
        else if (bus_wr && bus_addr == OFF_SEND) sig_out <= id_hot;
        else                                     sig_out <= '0;
    end

    // Registered read data; zero for unmapped offsets and idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                              bus_rdata <= '0;
        else if (bus_rd && bus_addr == OFF_RECV) bus_rdata <= recv_id;
        else                                     bus_rdata <= '0;
    end

    AST_SEND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sig_out)); // R2
    AST_SEND_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_SEND && id_ok) |=> (sig_out != '0)); // R2
    AST_SEND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_SEND && !id_ok) |=> (sig_out == '0)); // R10
    AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (recv_id != NONE_ID)); // R9
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R13
endmodule

// File: tb/test_sig_irq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_sig_irq_ctrl;
    localparam int NC = 4;
    localparam int NS = 8;
    localparam int NL = NC * NS;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] sig_in = '0;
    logic [NL-1:0] sig_out;
    logic          irq_out;
    int            checks = 0, fails = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    sig_irq_ctrl #(.NUM_CLIENTS(NC), .NUM_SIGNALS(NS)) i_sig_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sig_in(sig_in), .sig_out(sig_out), .irq_out(irq_out)
    );

    function automatic logic [31:0] mk(int c, int s);
        return {16'(c), 16'(s)};
    endfunction

    function automatic logic [NL-1:0] ln(int c, int s);
        logic [NL-1:0] v = '0;
        v[c*NS+s] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; bus_addr = '0;
        d = bus_rdata;
    endtask

    task automatic pulse(logic [NL-1:0] v);
        @(negedge clk); sig_in = v;
        @(negedge clk); sig_in = '0;
    endtask

    task automatic expect_recv(string req, logic [31:0] exp);
        logic [31:0] d;
        rd(8'h10, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R12 irq", irq_out, 0);
        chk("R12 sig_out", sig_out, 0);
        chk("R12 rdata", bus_rdata, 0);
        expect_recv("R12 R6 recv", NONE);
    endtask

    task automatic t_send();
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = mk(2, 5);
        @(negedge clk); bus_wr = 1'b0;
        chk("R2 R1 pulse", sig_out, ln(2, 5));
        @(negedge clk);
        chk("R2 one cycle", sig_out, 0);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = mk(4, 0);
        @(negedge clk); chk("R10 client oor", sig_out, 0);
        bus_wdata = mk(0, 8);
        @(negedge clk); bus_wr = 1'b0;
        chk("R10 signal oor", sig_out, 0);
    endtask

    task automatic t_disabled_pend();
        pulse(ln(1, 3));
        chk("R3 irq while disabled", irq_out, 0);
        expect_recv("R3 hidden", NONE);
        wr(8'h14, mk(1, 3));
        chk("R4 R9 irq", irq_out, 1);
        expect_recv("R5 R1 id", mk(1, 3));
        wr(8'h1C, mk(1, 3));
        expect_recv("R7 cleared", NONE);
        chk("R9 irq low", irq_out, 0);
    endtask

    task automatic t_priority();
        wr(8'h14, mk(3, 1)); wr(8'h14, mk(0, 6)); wr(8'h14, mk(3, 0));
        pulse(ln(3, 1) | ln(0, 6) | ln(3, 0));
        expect_recv("R5 lowest client", mk(0, 6));
        expect_recv("R13 no side effect", mk(0, 6));
        wr(8'h1C, mk(0, 6));
        expect_recv("R5 lowest signal", mk(3, 0));
        wr(8'h1C, mk(3, 0));
        expect_recv("R5 next", mk(3, 1));
        wr(8'h1C, mk(3, 1));
        expect_recv("R6 drained", NONE);
    endtask

    task automatic t_disable_one();
        wr(8'h14, mk(2, 2)); wr(8'h14, mk(2, 3));
        pulse(ln(2, 2) | ln(2, 3));
        expect_recv("R4 both on", mk(2, 2));
        wr(8'h18, mk(2, 2));
        expect_recv("R4 only addressed off", mk(2, 3));
        chk("R9 still high", irq_out, 1);
    endtask

    task automatic t_client_clear();
        pulse(ln(1, 3) | ln(2, 3));
        wr(8'h38, 32'd4);
        expect_recv("R10 client clear oor", mk(1, 3));
        wr(8'h38, 32'd1);
        expect_recv("R8 client 1 gone", mk(2, 3));
        wr(8'h38, 32'd2);
        expect_recv("R8 client 2 gone", NONE);
        wr(8'h14, mk(2, 2));
        expect_recv("R8 disabled line cleared", NONE);
        chk("R8 irq low", irq_out, 0);
    endtask

    task automatic t_set_wins();
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = mk(1, 3);
        sig_in = ln(1, 3);
        @(negedge clk); bus_wr = 1'b0; sig_in = '0;
        expect_recv("R11 set wins", mk(1, 3));
        wr(8'h1C, mk(1, 3));
        expect_recv("R11 then clear", NONE);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'h20, d);
        chk("R13 unmapped read", d, 0);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = mk(0, 0);
        @(negedge clk); bus_wr = 1'b0;
        chk("R13 no pulse", sig_out, 0);
        pulse(ln(0, 0));
        chk("R13 no enable", irq_out, 0);
        expect_recv("R13 still hidden", NONE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_send();
        t_disabled_pend();
        t_priority();
        t_disable_one();
        t_client_clear();
        t_set_wins();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule